// File: doc/BRIEF.md
# Programmable Line Waveform Sequencer

This block produces the control waveforms that a sensor readout needs on every line. It does not decode them from fixed logic. A table of 32 entries holds them. Each entry pairs a 9-bit control pattern with an 11-bit column position. A column counter runs across each line. A pointer selects the current entry. When the counter equals that entry's position, the entry's pattern is loaded into the control outputs and the pointer moves on to the next entry. At the start of every line the pointer returns to entry 0, so the same waveform repeats on each line.

The table is loaded through a plain address/data write port while the counting enable is low. With the enable high the sequencer runs and table writes have no effect. Besides the control vector, the block drives a pulse on the last column of each line and the current column number. The line length is an input and is usually 1500 clocks.

Top module: `wave_timing_gen`

## Requirements
- R1: After reset, `ctrlOut` is 0, `colCount` is 0 and `lineEnd` is 0.
- R2: While `countEn` is 0, `colCount` stays at 0, `ctrlOut` stays at 0 and `lineEnd` stays low.
- R3: With `countEn` high, `colCount` steps by one each clock from 0 to `width`-1 and then wraps to 0. `lineEnd` is high exactly in the cycle where `colCount` equals `width`-1. `width` must be at least 2.
- R4: A table word carries the control pattern in bits 19:11 and the column position in bits 10:0. When `colCount` equals the position of the current entry, `ctrlOut` shows that entry's pattern from the next clock onward.
- R5: Between two matches, `ctrlOut` keeps the last pattern that was applied.
- R6: The pointer goes back to entry 0 after the last column of each line, so the waveform repeats identically on every line.
- R7: Entries must be stored in ascending position order. An entry whose position is at or beyond `width` is never applied, and no entry after it is reached in that line.
- R8: Once entry 31 has been applied, `ctrlOut` does not change again until the next line starts.
- R9: A write presented while `countEn` is 1 leaves the table unchanged.
- R10: When `countEn` drops, `ctrlOut` and `colCount` return to 0 on the next clock. When counting restarts, the line begins again at column 0 and entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| countEn | input | 1 | 1 runs the sequencer; 0 stops it and allows table writes |
| width | input | 11 | Line length in clocks |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 5 | Table entry index to write |
| wrData | input | 20 | Entry word: bits 19:11 pattern, bits 10:0 position |
| ctrlOut | output | 9 | Applied control pattern |
| lineEnd | output | 1 | High in the last column of a line |
| colCount | output | 11 | Current column |

## Verification
On every cycle the assertions check the counter's step and wrap rules, that the counter stays at zero while stopped, that the pointer returns to entry 0 after each line end, that the control outputs hold between matches and clear when counting stops, and that no entry is applied once the pointer has run past entry 31. Whether the right pattern appears in the right column can only be shown by the bench scenarios. The same holds for stalling on an entry beyond the line width, for a write during counting being ignored, and for the waveform repeating unchanged across lines. Those checks need a known table and a column-by-column expectation.

// File: rtl/wtg_pkg.sv
package wtg_pkg;
  parameter int CTRL_W = 9;
  parameter int POS_W  = 11;
  parameter int DEPTH  = 32;
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int ENTRY_W = CTRL_W + POS_W;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic write;     // accepted table write
    logic apply;     // current entry matches the column
    logic clearPtr;  // last column of the line
    logic clearAll;  // counting stopped
  } strobe_t;
endpackage

// File: rtl/wtg_ctrl.sv
module wtg_ctrl
  import wtg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             wrEn,
  input  logic [POS_W-1:0] width,
  input  logic [POS_W-1:0] curPos,
  input  logic             ptrEnd,
  output logic [POS_W-1:0] colCount,
  output logic             lineEnd,
  output strobe_t          stb
);
  logic [POS_W-1:0] col;
  logic [POS_W-1:0] lastCol;
  logic             atEnd;

  assign lastCol = width - 1'b1;
  assign atEnd   = (col == lastCol);

  always_ff @(posedge clk) begin
    if (!rstN)        col <= '0;
    else if (!countEn) col <= '0;
    else if (atEnd)   col <= '0;
    else              col <= col + 1'b1;
  end

  always_comb begin
    stb.write    = wrEn && !countEn;
    stb.clearAll = !countEn;
    stb.apply    = countEn && !ptrEnd && (curPos == col);
    stb.clearPtr = countEn && atEnd;
  end

  assign colCount = col;
  assign lineEnd  = countEn && atEnd;

  // R3: wrap after the last column
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> colCount == '0);
  // R3: single step inside a line
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    countEn && !lineEnd |=> colCount == $past(colCount) + 1'b1);
  // R2: counter parked while stopped
  a_r2_idle: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> colCount == '0);
endmodule

// File: rtl/wtg_datapath.sv
module wtg_datapath
  import wtg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [POS_W-1:0]  curPos,
  output logic              ptrEnd,
  output logic [CTRL_W-1:0] ctrlOut
);
  logic [ENTRY_W-1:0] tbl [DEPTH];
  logic [IDX_W:0]     ptr;
  logic [ENTRY_W-1:0] curEntry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (stb.write) begin
      tbl[wrAddr] <= wrData;
    end
  end

  assign curEntry = tbl[ptr[IDX_W-1:0]];
  assign curPos   = curEntry[POS_W-1:0];
  assign ptrEnd   = (ptr == (IDX_W+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN)                          ptr <= '0;
    else if (stb.clearAll || stb.clearPtr) ptr <= '0;
    else if (stb.apply)                 ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             ctrlOut <= '0;
    else if (stb.clearAll) ctrlOut <= '0;
    else if (stb.apply)    ctrlOut <= curEntry[ENTRY_W-1:POS_W];
  end

  // R5: outputs hold without a match
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clearAll && !stb.apply |=> $stable(ctrlOut));
  // R6: pointer back to entry 0 after a line end
  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearPtr |=> ptr == '0);
  // R8: nothing applied once the table is exhausted
  a_r8_exhausted: assert property (@(posedge clk) disable iff (!rstN)
    ptrEnd |-> !stb.apply);
  // R10: stopping clears the pattern
  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> ctrlOut == '0);
endmodule

// File: rtl/wave_timing_gen.sv
module wave_timing_gen
  import wtg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic [POS_W-1:0]  width,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              lineEnd,
  output logic [POS_W-1:0]  colCount
);
  strobe_t          stb;
  logic [POS_W-1:0] curPos;
  logic             ptrEnd;

  wtg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .countEn(countEn), .wrEn(wrEn), .width(width),
    .curPos(curPos), .ptrEnd(ptrEnd), .colCount(colCount), .lineEnd(lineEnd),
    .stb(stb)
  );

  wtg_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .wrData(wrData),
    .curPos(curPos), .ptrEnd(ptrEnd), .ctrlOut(ctrlOut)
  );
endmodule

// File: tb/wave_timing_gen_test.sv
module wave_timing_gen_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        countEn = 0;
  logic [10:0] width = 11'd24;
  logic        wrEn = 0;
  logic [4:0]  wrAddr = '0;
  logic [19:0] wrData = '0;
  logic [8:0]  ctrlOut;
  logic        lineEnd;
  logic [10:0] colCount;

  int checks = 0;
  int failures = 0;
  logic nextEn = 0;

  // reference state built from the requirements
  logic [19:0] mTab [32];
  int eCol = 0;
  int ePtr = 0;
  int eCtrl = 0;

  // table for the first scenario: {pattern, position}, ascending positions
  localparam logic [19:0] VEC [8] = '{
    {9'h1A5, 11'd0},  {9'h0F0, 11'd3},  {9'h10F, 11'd7},  {9'h055, 11'd12},
    {9'h1FF, 11'd20}, {9'h0AA, 11'd23}, {9'h133, 11'd24}, {9'h0CC, 11'd30}
  };

  wave_timing_gen uut (
    .clk(clk), .rstN(rstN), .countEn(countEn), .width(width), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .ctrlOut(ctrlOut), .lineEnd(lineEnd),
    .colCount(colCount)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: compare at the falling edge, drive inputs, advance the model
  task automatic stepCycle(input string tag, input bit we, input int addr,
                           input logic [19:0] d);
    bit match;
    @(negedge clk);
    chk({tag, " colCount"}, int'(colCount), eCol);
    chk({tag, " lineEnd"}, int'(lineEnd), (countEn && eCol == int'(width) - 1) ? 1 : 0);
    chk({tag, " ctrlOut"}, int'(ctrlOut), eCtrl);
    countEn = nextEn;
    wrEn = we; wrAddr = 5'(addr); wrData = d;
    if (we && !countEn) mTab[addr] = d;
    if (!countEn) begin
      eCol = 0; ePtr = 0; eCtrl = 0;
    end else begin
      match = 0;
      if (ePtr < 32) match = (int'(mTab[ePtr][10:0]) == eCol);
      if (match) eCtrl = int'(mTab[ePtr][19:11]);
      if (eCol == int'(width) - 1) begin
        eCol = 0; ePtr = 0;
      end else begin
        if (match) ePtr++;
        eCol++;
      end
    end
  endtask

  task automatic runCycles(input string tag, input int n, input int wrAt,
                           input logic [19:0] d);
    for (int i = 0; i < n; i++) stepCycle(tag, (i == wrAt), 0, d);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mTab[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset values
    @(negedge clk);
    chk("R1 ctrlOut", int'(ctrlOut), 0);
    chk("R1 colCount", int'(colCount), 0);
    chk("R1 lineEnd", int'(lineEnd), 0);

    // load: vector rows then stop entries; R2 checked every cycle meanwhile
    nextEn = 0;
    for (int i = 0; i < 32; i++)
      stepCycle("R2 load", 1, i, (i < 8) ? VEC[i] : {9'h1EE, 11'd2047});
    stepCycle("R2 idle", 0, 0, '0);

    // R3 R4 R5 R6 R7: two lines of 24; entry 6 at position 24 stalls the pointer
    nextEn = 1;
    runCycles("R4/R5/R6/R7", 49, -1, '0);

    // R9: write to entry 0 while running must be ignored
    runCycles("R9 write", 24, 5, {9'h011, 11'd0});
    runCycles("R9 after", 24, -1, '0);

    // R10: stop mid-line, then restart at column 0 and entry 0
    runCycles("R10 pre", 9, -1, '0);
    nextEn = 0;
    runCycles("R10 stop", 4, -1, '0);
    nextEn = 1;
    runCycles("R10 restart", 10, -1, '0);
    nextEn = 0;
    stepCycle("R10 halt", 0, 0, '0);

    // R8: all 32 entries used, positions 2*i, width 80
    width = 11'd80;
    for (int i = 0; i < 32; i++)
      stepCycle("R8 load", 1, i, {9'(i + 1), 11'(2 * i)});
    nextEn = 1;
    runCycles("R8", 161, -1, '0);

    // R3: full default-length line of 1500 clocks
    nextEn = 0;
    stepCycle("R3 stop", 0, 0, '0);
    width = 11'd1500;
    nextEn = 1;
    runCycles("R3 long", 1503, -1, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule